// File: doc/BRIEF.md
# Phase-Cycled Signal Permutation Router

This block re-orders the bits of a wide detector data word so that signals grouped by detector layer and azimuthal position come out grouped by wedge-shaped trigger sector. A beam crossing spans exactly seven system clock ticks. The crossing's data arrives as seven slices, one slice per tick. Each slice belongs to a tick phase from 0 to 6, and each phase has its own permutation map. The re-ordered slice leaves a fixed number of ticks later. Its valid flag, its phase and its crossing-start marker travel alongside it.

The phase is kept in step by a crossing-start strobe that arrives with the first slice of each crossing. A strobe that arrives when the tracker does not expect phase 0 sets a sticky misalignment flag. Each map stores one source index for every output bit. The maps are loaded one entry at a time through a write port, and a write is accepted only while no slice is being presented. The pipeline latency is a parameter. Elaboration stops unless the latency lies between 1 and 6 ticks, which keeps it below one crossing period. Elaboration also requires the slice width to be a power of two.

Top module: `perm_router`

## Requirements
- R1: After reset, every phase map is the identity (output bit j takes input bit j), so each slice leaves unchanged.
- R2: Output bit j of a slice equals input bit `map[phase][j]`. A slice presented with `in_valid` high before rising edge t is on the outputs, with `out_valid` high, after edge t+LATENCY-1. That is LATENCY rising edges later; the default LATENCY is 2.
- R3: A valid slice with `in_start` high gets phase 0. Each later valid slice without `in_start` gets the previous phase plus one, and phase 6 wraps to 0. Cycles with `in_valid` low do not advance the phase. The first slice after reset without a strobe gets phase 0.
- R4: A valid slice with `in_start` high, arriving when the expected phase is not 0, sets `misalign` on the next edge. The flag stays high until reset. A strobe that arrives at expected phase 0 leaves the flag low.
- R5: `out_phase` and `out_start` carry the phase and start marker of the slice on `out_slice`. Every slice with `out_start` high has `out_phase` equal to 0.
- R6: `out_valid` is low after reset, and it is low whenever the input was idle LATENCY edges earlier.
- R7: The write `cfg_we` stores `cfg_src` as the source index for output bit `cfg_out_idx` of phase `cfg_phase`. It takes effect for slices presented after the write edge. The write is ignored when `in_valid` is high in the same cycle, and it is ignored when `cfg_phase` is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, seven ticks per crossing |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Map entry write strobe |
| cfg_phase | input | 3 | Phase whose map is written (0..6) |
| cfg_out_idx | input | log2(N_BITS) | Output bit whose source is written |
| cfg_src | input | log2(N_BITS) | Source input bit index to store |
| in_valid | input | 1 | Slice present this cycle |
| in_start | input | 1 | Slice is the first of a crossing |
| in_slice | input | N_BITS | Slice in layer order |
| out_valid | output | 1 | Routed slice present |
| out_start | output | 1 | Routed slice was first of its crossing |
| out_phase | output | 3 | Phase of the routed slice |
| out_slice | output | N_BITS | Slice in trigger-sector order |
| misalign | output | 1 | Sticky crossing-start misalignment flag |

## Verification
A slice driven at a falling edge is captured on the next rising edge. With LATENCY 2 its routed value, phase and start marker are due two rising edges after it is driven. The streaming loop therefore compares output k at the falling edge on which input k+LATENCY is driven. In the leading LATENCY iterations of each burst, the loop checks that `out_valid` is low, because those outputs come from idle cycles. `misalign` is registered and is due one edge after the offending strobe, so it is read once the burst has drained. A map write counts from the edge that stores it, so the slices sent after the write expect the new map, and a write refused while a slice is present must leave the old map in use.

// File: rtl/perm_route_pkg.sv
package perm_route_pkg;
   localparam int unsigned CROSS_TICKS = 7;
   localparam int unsigned PH_W        = 3;

   typedef logic [PH_W-1:0] phase_t;

   function automatic phase_t phase_advance(input phase_t p);
      return (p == phase_t'(CROSS_TICKS - 1)) ? '0 : phase_t'(p + 1'b1);
   endfunction
endpackage

// File: rtl/perm_phase_tracker.sv
module perm_phase_tracker
   import perm_route_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   in_valid,
   input  logic   in_start,
   output phase_t cur_phase,
   output logic   misalign
);

   phase_t expect_q;

   // a strobe forces phase 0; otherwise the expected phase is used
   assign cur_phase = in_start ? '0 : expect_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expect_q <= '0;
         misalign <= 1'b0;
      end else if (in_valid) begin
         expect_q <= phase_advance(cur_phase);
         if (in_start && (expect_q != '0))
            misalign <= 1'b1;
      end
   end

   p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (cur_phase < phase_t'(CROSS_TICKS)));

   p_phase_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_start && $past(in_valid) && $past(rst_n))
         |-> (cur_phase == phase_advance($past(cur_phase))));

   p_misalign_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |=> misalign);

   p_misalign_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(misalign) |-> $past(in_valid && in_start));

endmodule

// File: rtl/perm_map_store.sv
module perm_map_store
   import perm_route_pkg::*;
#(
   parameter int N_BITS = 16,
   localparam int IDXW  = $clog2(N_BITS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_we,
   input  logic                       busy,
   input  phase_t                     cfg_phase,
   input  logic [IDXW-1:0]            cfg_out_idx,
   input  logic [IDXW-1:0]            cfg_src,
   input  phase_t                     rd_phase,
   output logic [N_BITS-1:0][IDXW-1:0] rd_map
);

   generate
      if (N_BITS < 2 || (N_BITS & (N_BITS - 1)) != 0) begin : g_bad_width
         $error("perm_map_store: N_BITS must be a power of two and at least 2");
      end
   endgenerate

   logic [CROSS_TICKS-1:0][N_BITS-1:0][IDXW-1:0] map_q;
   logic wr_ok;

   assign wr_ok = cfg_we && !busy && (cfg_phase < phase_t'(CROSS_TICKS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < int'(CROSS_TICKS); p++)
            for (int j = 0; j < N_BITS; j++)
               map_q[p][j] <= IDXW'(j);
      end else if (wr_ok) begin
         map_q[cfg_phase][cfg_out_idx] <= cfg_src;
      end
   end

   assign rd_map = map_q[rd_phase];

   p_busy_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && busy) |=> $stable(map_q));

   p_bad_phase_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_phase == phase_t'(CROSS_TICKS)) |=> $stable(map_q));

   p_idle_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(map_q));

endmodule

// File: rtl/perm_crossbar_pipe.sv
module perm_crossbar_pipe
   import perm_route_pkg::*;
#(
   parameter int N_BITS  = 16,
   parameter int LATENCY = 2,
   localparam int IDXW   = $clog2(N_BITS),
   localparam int WARM_W = $clog2(LATENCY + 1) + 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic                       in_start,
   input  phase_t                     in_phase,
   input  logic [N_BITS-1:0]          in_slice,
   input  logic [N_BITS-1:0][IDXW-1:0] sel_map,
   output logic                       out_valid,
   output logic                       out_start,
   output phase_t                     out_phase,
   output logic [N_BITS-1:0]          out_slice
);

   generate
      if (LATENCY < 1 || LATENCY >= int'(CROSS_TICKS)) begin : g_bad_latency
         $error("perm_crossbar_pipe: LATENCY must lie in 1..6");
      end
   endgenerate

   logic [N_BITS-1:0] routed;

   always_comb begin
      for (int j = 0; j < N_BITS; j++)
         routed[j] = in_slice[sel_map[j]];
   end

   logic [LATENCY-1:0] v_q;
   logic [LATENCY-1:0] s_q;
   phase_t             ph_q [LATENCY];
   logic [N_BITS-1:0]  d_q  [LATENCY];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= '0;
         s_q <= '0;
         for (int s = 0; s < LATENCY; s++) begin
            ph_q[s] <= '0;
            d_q[s]  <= '0;
         end
      end else begin
         v_q[0]  <= in_valid;
         s_q[0]  <= in_valid && in_start;
         ph_q[0] <= in_phase;
         d_q[0]  <= routed;
         for (int s = 1; s < LATENCY; s++) begin
            v_q[s]  <= v_q[s-1];
            s_q[s]  <= s_q[s-1];
            ph_q[s] <= ph_q[s-1];
            d_q[s]  <= d_q[s-1];
         end
      end
   end

   assign out_valid = v_q[LATENCY-1];
   assign out_start = s_q[LATENCY-1];
   assign out_phase = ph_q[LATENCY-1];
   assign out_slice = d_q[LATENCY-1];

   // counts edges since reset so that $past never reaches into reset
   logic [WARM_W-1:0] warm_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         warm_q <= '0;
      else if (warm_q != WARM_W'(LATENCY))
         warm_q <= warm_q + 1'b1;
   end

   p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == WARM_W'(LATENCY)) |-> (out_valid == $past(in_valid, LATENCY)));

   p_data_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((warm_q == WARM_W'(LATENCY)) && out_valid)
         |-> (out_slice == $past(routed, LATENCY)));

   p_phase_travels_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((warm_q == WARM_W'(LATENCY)) && out_valid)
         |-> (out_phase == $past(in_phase, LATENCY)));

endmodule

// File: rtl/perm_router.sv
module perm_router
   import perm_route_pkg::*;
#(
   parameter int N_BITS  = 16,
   parameter int LATENCY = 2,
   localparam int IDXW   = $clog2(N_BITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_phase,
   input  logic [IDXW-1:0]   cfg_out_idx,
   input  logic [IDXW-1:0]   cfg_src,
   input  logic              in_valid,
   input  logic              in_start,
   input  logic [N_BITS-1:0] in_slice,
   output logic              out_valid,
   output logic              out_start,
   output logic [2:0]        out_phase,
   output logic [N_BITS-1:0] out_slice,
   output logic              misalign
);

   phase_t                      cur_phase;
   logic [N_BITS-1:0][IDXW-1:0] cur_map;

   perm_phase_tracker u_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_start  (in_start),
      .cur_phase (cur_phase),
      .misalign  (misalign)
   );

   perm_map_store #(.N_BITS(N_BITS)) u_maps (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .busy        (in_valid),
      .cfg_phase   (cfg_phase),
      .cfg_out_idx (cfg_out_idx),
      .cfg_src     (cfg_src),
      .rd_phase    (cur_phase),
      .rd_map      (cur_map)
   );

   perm_crossbar_pipe #(.N_BITS(N_BITS), .LATENCY(LATENCY)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_start  (in_start),
      .in_phase  (cur_phase),
      .in_slice  (in_slice),
      .sel_map   (cur_map),
      .out_valid (out_valid),
      .out_start (out_start),
      .out_phase (out_phase),
      .out_slice (out_slice)
   );

   p_out_phase_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_phase < 3'd7));

   p_start_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_start) |-> (out_phase == 3'd0));

   p_start_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_start |-> out_valid);

endmodule

// File: tb/test_perm_router.sv
module test_perm_router;

   localparam int CLK_PERIOD = 10;
   localparam int N    = 16;
   localparam int LAT  = 2;
   localparam int IDXW = 4;
   localparam int TBL_N = 14;

   // {start, expected phase, slice}
   localparam logic [19:0] TBL [TBL_N] = '{
      {1'b1, 3'd0, 16'h8001}, {1'b0, 3'd1, 16'h1234}, {1'b0, 3'd2, 16'hFFFF},
      {1'b0, 3'd3, 16'h0000}, {1'b0, 3'd4, 16'hA5A5}, {1'b0, 3'd5, 16'h00F0},
      {1'b0, 3'd6, 16'h7E81}, {1'b1, 3'd0, 16'h0001}, {1'b0, 3'd1, 16'h8000},
      {1'b0, 3'd2, 16'h5A5A}, {1'b0, 3'd3, 16'hC003}, {1'b0, 3'd4, 16'h0FF0},
      {1'b0, 3'd5, 16'h3C3C}, {1'b0, 3'd6, 16'hDEAD}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [2:0] cfg_phase = '0;
   logic [IDXW-1:0] cfg_out_idx = '0;
   logic [IDXW-1:0] cfg_src = '0;
   logic in_valid = 1'b0;
   logic in_start = 1'b0;
   logic [N-1:0] in_slice = '0;
   logic out_valid, out_start, misalign;
   logic [2:0] out_phase;
   logic [N-1:0] out_slice;

   always #(CLK_PERIOD/2) clk = ~clk;

   perm_router #(.N_BITS(N), .LATENCY(LAT)) i_perm_router (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_phase(cfg_phase),
      .cfg_out_idx(cfg_out_idx), .cfg_src(cfg_src), .in_valid(in_valid),
      .in_start(in_start), .in_slice(in_slice), .out_valid(out_valid),
      .out_start(out_start), .out_phase(out_phase), .out_slice(out_slice),
      .misalign(misalign)
   );

   int n_chk = 0;
   int n_bad = 0;

   logic [IDXW-1:0] mm [7][N];
   logic [2:0] b_next;

   logic          q_start [32];
   logic [N-1:0]  q_slice [32];
   logic [2:0]    q_phase [32];
   int            q_n = 0;

   logic          bw_en = 1'b0;
   logic [2:0]    bw_ph = '0;
   logic [IDXW-1:0] bw_idx = '0;
   logic [IDXW-1:0] bw_src = '0;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [N-1:0] permute(input logic [2:0] ph, input logic [N-1:0] s);
      logic [N-1:0] r;
      for (int j = 0; j < N; j++) r[j] = s[mm[ph][j]];
      return r;
   endfunction

   function automatic logic [2:0] adv(input logic [2:0] p);
      return (p == 3'd6) ? 3'd0 : p + 3'd1;
   endfunction

   task automatic push(input logic st, input logic [N-1:0] s);
      logic [2:0] ph;
      ph = st ? 3'd0 : b_next;
      b_next = adv(ph);
      q_start[q_n] = st;
      q_slice[q_n] = s;
      q_phase[q_n] = ph;
      q_n++;
   endtask

   task automatic push_crossing();
      push(1'b1, N'($urandom));
      for (int i = 1; i < 7; i++) push(1'b0, N'($urandom));
   endtask

   task automatic run_stream(input string req);
      for (int j = 0; j < q_n + LAT; j++) begin
         @(negedge clk);
         if (j >= LAT) begin
            chk(req, "out_valid", 32'(out_valid), 32'd1);
            chk(req, "out_slice", 32'(out_slice), 32'(permute(q_phase[j-LAT], q_slice[j-LAT])));
            chk("R5", "out_phase", 32'(out_phase), 32'(q_phase[j-LAT]));
            chk("R5", "out_start", 32'(out_start), 32'(q_start[j-LAT]));
         end else begin
            chk("R6", "out_valid idle", 32'(out_valid), 32'd0);
         end
         cfg_we = 1'b0;
         if (j < q_n) begin
            in_valid = 1'b1;
            in_start = q_start[j];
            in_slice = q_slice[j];
            if (j == 0 && bw_en) begin
               cfg_we = 1'b1; cfg_phase = bw_ph; cfg_out_idx = bw_idx; cfg_src = bw_src;
            end
         end else begin
            in_valid = 1'b0; in_start = 1'b0; in_slice = '0;
         end
      end
      q_n = 0;
      bw_en = 1'b0;
   endtask

   task automatic cfg_write(input logic [2:0] ph, input logic [IDXW-1:0] idx,
                            input logic [IDXW-1:0] src);
      @(negedge clk);
      in_valid = 1'b0;
      cfg_we = 1'b1; cfg_phase = ph; cfg_out_idx = idx; cfg_src = src;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0; in_start = 1'b0; cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int p = 0; p < 7; p++)
         for (int j = 0; j < N; j++) mm[p][j] = IDXW'(j);
      b_next = 3'd0;
      q_n = 0;
   endtask

   task automatic load_table();
      for (int i = 0; i < TBL_N; i++) begin
         q_start[i] = TBL[i][19];
         q_phase[i] = TBL[i][18:16];
         q_slice[i] = TBL[i][15:0];
      end
      q_n = TBL_N;
      b_next = 3'd0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [IDXW-1:0] perm [N];
      logic [IDXW-1:0] old_src;

      do_reset();
      @(negedge clk);
      chk("R6", "out_valid after reset", 32'(out_valid), 32'd0);
      chk("R4", "misalign after reset", 32'(misalign), 32'd0);

      // R1: identity maps after reset
      load_table();
      run_stream("R1");

      // R2: random permutation per phase
      for (int p = 0; p < 7; p++) begin
         for (int j = 0; j < N; j++) perm[j] = IDXW'(j);
         for (int j = N-1; j > 0; j--) begin
            int k;
            logic [IDXW-1:0] t;
            k = int'($urandom % (j + 1));
            t = perm[j]; perm[j] = perm[k]; perm[k] = t;
         end
         for (int j = 0; j < N; j++) begin
            cfg_write(3'(p), IDXW'(j), perm[j]);
            mm[p][j] = perm[j];
         end
      end
      load_table();
      run_stream("R2");
      push_crossing();
      push_crossing();
      run_stream("R2");

      // R7: idle write takes effect
      cfg_write(3'd3, 4'd5, mm[3][5] + 4'd1);
      mm[3][5] = mm[3][5] + 4'd1;
      push_crossing();
      run_stream("R7");

      // R7: write during a valid slice is ignored
      old_src = mm[1][0];
      bw_en = 1'b1; bw_ph = 3'd1; bw_idx = 4'd0; bw_src = old_src + 4'd7;
      push_crossing();
      run_stream("R7");

      // R7: write to phase 7 is ignored
      cfg_write(3'd7, 4'd2, mm[0][2] + 4'd3);
      push_crossing();
      run_stream("R7");
      chk("R4", "misalign aligned traffic", 32'(misalign), 32'd0);

      // R3: idle cycles do not advance the phase
      push(1'b1, 16'h1111); push(1'b0, 16'h2222); push(1'b0, 16'h4444);
      run_stream("R3");
      repeat (5) @(negedge clk);
      push(1'b0, 16'h8888); push(1'b0, 16'h9999);
      run_stream("R3");
      push(1'b0, 16'hAAAA); push(1'b0, 16'hBBBB); push(1'b1, 16'hCCCC);
      run_stream("R3");
      chk("R4", "misalign strobe at wrap", 32'(misalign), 32'd0);

      // R4: strobe at an unexpected phase
      push(1'b0, 16'h0F0F); push(1'b1, 16'hF0F0);
      run_stream("R3");
      chk("R4", "misalign set", 32'(misalign), 32'd1);
      push_crossing();
      run_stream("R2");
      chk("R4", "misalign sticky", 32'(misalign), 32'd1);

      // reset clears flag and restores identity maps
      do_reset();
      @(negedge clk);
      chk("R4", "misalign cleared by reset", 32'(misalign), 32'd0);
      chk("R6", "out_valid after second reset", 32'(out_valid), 32'd0);
      push(1'b0, 16'h1357);
      push_crossing();
      run_stream("R1");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule